// File: doc/BRIEF.md
# Bus Clock Divisor Selection Engine

This block works out the clock divider settings for a clock tree with three clocks: a core clock, a high-speed bus clock taken from it, and a peripheral bus clock taken from the bus clock. A start strobe captures four unsigned 32-bit frequencies in Hz. These are the core clock, the requested processor clock, the limit for the high-speed bus and the limit for the peripheral bus. The engine then looks for the smallest high-speed bus divisor whose bus clock respects the limit, with a small tolerance. Next it chooses a peripheral ratio of 1 or 2. Last, it decides whether the processor should be clocked from the bus clock, which is the reduced-voltage operating mode.

Each candidate divisor is checked with a restoring divider that produces one quotient bit per cycle. This keeps the datapath to one narrow subtractor. When the answer, or a failure, is ready, the block raises a one-cycle completion pulse. A failure is reported through a flag and leaves the previous settings in place. The block only computes the settings and does not program the clock generator.

Top module: `busdiv_select`

## Requirements
- R1: The bus divisor is the first accepted value in the sequence 1, 2, 3, 4, 6, 8. The values 5 and 7 are never reported. `hdiv` carries the divisor value in binary.
- R2: A candidate d is accepted when floor(core/d) is no greater than the bus limit plus 1000 Hz.
- R3: A requested processor frequency above the core frequency is treated as equal to the core frequency.
- R4: When the clamped request is below both the core frequency and the bus limit, the request replaces the bus limit.
- R5: When no candidate up to 8 is accepted, `invalid` is 1 in the `done` cycle, and `hdiv`, `pdiv`, `dvs_mode` and `cpu_hz` keep their previous values.
- R6: The peripheral ratio is 2 when the bus clock is above the peripheral limit, and 1 otherwise. When the ratio is 2 and floor(bus/2) is still above the limit, the result is invalid and the outputs are held as in R5.
- R7: `pdiv` is the peripheral ratio times the bus divisor.
- R8: The processor frequency is first raised to the bus clock if it is below it. If it is still below the core frequency, `dvs_mode` is 1 and `cpu_hz` equals the bus clock. Otherwise `dvs_mode` is 0 and `cpu_hz` equals the core frequency.
- R9: `done` is high for exactly one cycle per accepted start. A valid result clears `invalid`.
- R10: A start pulse that arrives while a calculation is running is ignored. It changes neither the result nor the number of `done` pulses.
- R11: After reset, `hdiv`=1, `pdiv`=1, `dvs_mode`=0, `cpu_hz`=0, `done`=0 and `invalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a calculation when idle |
| core_hz | input | 32 | Core clock frequency in Hz |
| cpu_req_hz | input | 32 | Requested processor frequency in Hz |
| hbus_max_hz | input | 32 | High-speed bus limit in Hz |
| pbus_max_hz | input | 32 | Peripheral bus limit in Hz |
| hdiv | output | 4 | Chosen bus divisor |
| pdiv | output | 5 | Total peripheral divisor from the core clock |
| dvs_mode | output | 1 | Processor is clocked from the bus clock |
| cpu_hz | output | 32 | Adjusted processor frequency in Hz |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Last calculation found no legal setting |

## Verification
The assertions check, on every cycle, the structural properties of each result. The completion pulse lasts one cycle. A reported bus divisor is always in the legal set. The peripheral divisor is always one or two times the bus divisor. `cpu_hz` is below the core frequency exactly when the mode flag is set. A failed calculation leaves the previous outputs untouched. Operands latched for a running calculation never change.

Other properties depend on arithmetic against inputs, so only the bench scenarios can show them. These are the smallest accepted divisor, the 1 kHz tolerance edge, the request clamp, the lowering of the bus limit, and the peripheral-ratio failure. For these, the bench compares each result with a reference model over random and directed frequency sets.

// File: rtl/busdiv_select.sv
module busdiv_select #(
  parameter int W      = 32,
  parameter int TOL_HZ = 1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] core_hz,
  input  logic [W-1:0] cpu_req_hz,
  input  logic [W-1:0] hbus_max_hz,
  input  logic [W-1:0] pbus_max_hz,
  output logic [3:0]   hdiv,
  output logic [4:0]   pdiv,
  output logic         dvs_mode,
  output logic [W-1:0] cpu_hz,
  output logic         done,
  output logic         invalid
);
  localparam int CW = $clog2(W);
  localparam logic [2:0] LAST_IDX = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_CHK} st_t;
  st_t st;

  logic [W-1:0]  core_q, cpu_q, lim_q, pmax_q, quo;
  logic [3:0]    rem;
  logic [2:0]    idx;
  logic [CW-1:0] cnt;

  function automatic logic [3:0] cand(input logic [2:0] i);
    case (i)
      3'd0: cand = 4'd1;
      3'd1: cand = 4'd2;
      3'd2: cand = 4'd3;
      3'd3: cand = 4'd4;
      3'd4: cand = 4'd6;
      default: cand = 4'd8;
    endcase
  endfunction

  // R3, R4: request clamp and bus limit lowering at capture
  wire [W-1:0] clamp_hz = (cpu_req_hz > core_hz) ? core_hz : cpu_req_hz;
  wire [W-1:0] lim_hz   = (clamp_hz < core_hz && clamp_hz < hbus_max_hz) ? clamp_hz : hbus_max_hz;

  // restoring divider step: remainder stays below the divisor (<= 8)
  wire [3:0] dsr   = cand(idx);
  wire [4:0] trial = {rem, quo[W-1]};
  wire       ge    = trial >= {1'b0, dsr};

  // candidate evaluation once the quotient is complete
  wire         fits   = {1'b0, quo} <= ({1'b0, lim_q} + (W+1)'(TOL_HZ));
  wire         hi_p   = quo > pmax_q;
  wire         pbad   = hi_p && ((quo >> 1) > pmax_q);
  wire [W-1:0] cpu_up = (cpu_q < quo) ? quo : cpu_q;
  wire         dvs_n  = cpu_up < core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      core_q <= '0; cpu_q <= '0; lim_q <= '0; pmax_q <= '0;
      quo <= '0; rem <= '0; idx <= '0; cnt <= '0;
      hdiv <= 4'd1; pdiv <= 5'd1; dvs_mode <= 1'b0; cpu_hz <= '0;
      done <= 1'b0; invalid <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          core_q <= core_hz; cpu_q <= clamp_hz; lim_q <= lim_hz; pmax_q <= pbus_max_hz;
          idx <= '0; rem <= '0; quo <= core_hz; cnt <= '0;
          st <= S_DIV;
        end
        S_DIV: begin
          rem <= ge ? 4'(trial - {1'b0, dsr}) : trial[3:0];
          quo <= {quo[W-2:0], ge};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W-1)) st <= S_CHK;
        end
        S_CHK: begin
          if (fits) begin
            done <= 1'b1;
            st <= S_IDLE;
            if (pbad) invalid <= 1'b1;
            else begin
              invalid  <= 1'b0;
              hdiv     <= dsr;
              pdiv     <= hi_p ? {dsr, 1'b0} : {1'b0, dsr};
              dvs_mode <= dvs_n;
              cpu_hz   <= dvs_n ? quo : cpu_up;
            end
          end else if (idx == LAST_IDX) begin
            done <= 1'b1; invalid <= 1'b1; st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1; rem <= '0; quo <= core_q; cnt <= '0;
            st <= S_DIV;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_hdiv_set: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid |-> (hdiv inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8}));
  a_r7_pdiv_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid |-> (pdiv == {1'b0, hdiv} || pdiv == {hdiv, 1'b0}));
  a_r8_cpu_mode: assert property (@(posedge clk) disable iff (!rst_n)
    done && !invalid |-> (dvs_mode ? (cpu_hz < core_q) : (cpu_hz == core_q)));
  a_r5_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && invalid |-> ($stable(hdiv) && $stable(pdiv) && $stable(cpu_hz) && $stable(dvs_mode)));
  a_r10_busy_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(core_q) && $stable(lim_q) && $stable(pmax_q)));
endmodule

// File: tb/busdiv_select_test.sv
module busdiv_select_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] core_hz = '0, cpu_req_hz = '0, hbus_max_hz = '0, pbus_max_hz = '0;
  logic [3:0] hdiv; logic [4:0] pdiv; logic dvs_mode, done, invalid; logic [31:0] cpu_hz;
  int errors = 0, checks = 0;
  longint eh = 1, ep = 1, ed = 0, ec = 0;

  busdiv_select uut (.clk, .rst_n, .start, .core_hz, .cpu_req_hz, .hbus_max_hz,
    .pbus_max_hz, .hdiv, .pdiv, .dvs_mode, .cpu_hz, .done, .invalid);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_calc(input longint c, r, h, p, output bit ok,
                          output longint rh, rp, rd, rc);
    longint a, lim, hz, rat; int dv[6] = '{1, 2, 3, 4, 6, 8};
    ok = 0; rh = 0; rp = 0; rd = 0; rc = 0;
    a = (r > c) ? c : r;
    lim = (a < c && a < h) ? a : h;
    for (int i = 0; i < 6; i++) begin
      hz = c / dv[i];
      if (hz <= lim + 1000) begin
        rat = (hz > p) ? 2 : 1;
        if (hz / rat > p) rat++;
        if (rat > 2) return;
        if (a < hz) a = hz;
        ok = 1; rh = dv[i]; rp = rat * dv[i];
        rd = (a < c) ? 1 : 0; rc = (a < c) ? hz : a;
        return;
      end
    end
  endtask

  task automatic run(input longint c, r, h, p, input string tag, input bit busy_poke);
    bit ok; longint rh, rp, rd, rc; int n;
    ref_calc(c, r, h, p, ok, rh, rp, rd, rc);
    @(negedge clk);
    core_hz = 32'(c); cpu_req_hz = 32'(r); hbus_max_hz = 32'(h); pbus_max_hz = 32'(p);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (busy_poke) begin
      repeat (10) @(negedge clk);
      core_hz = 32'd12345; cpu_req_hz = 32'd1; hbus_max_hz = 32'd1; pbus_max_hz = 32'd1;
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin
      chk(0, {tag, " watchdog, no done"}, 0, 1);
      return;
    end
    if (ok) begin eh = rh; ep = rp; ed = rd; ec = rc; end
    chk(invalid == !ok, {tag, " R5/R6 invalid flag"}, invalid, !ok);
    chk(hdiv == eh, {tag, " R1 hdiv"}, hdiv, eh);
    chk(pdiv == ep, {tag, " R7 pdiv"}, pdiv, ep);
    chk(dvs_mode == ed, {tag, " R8 dvs_mode"}, dvs_mode, ed);
    chk(cpu_hz == ec, {tag, " R8 cpu_hz"}, cpu_hz, ec);
    @(negedge clk);
    chk(!done, {tag, " R9 done single cycle"}, done, 0);
    if (busy_poke) begin
      n = 0;
      repeat (300) begin @(negedge clk); if (done) n++; end
      chk(n == 0, "R10 extra done after ignored start", n, 0);
      chk(hdiv == eh, "R10 result kept", hdiv, eh);
    end
  endtask

  initial begin
    longint c, h, p, r; int m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(hdiv == 1, "R11 reset hdiv", hdiv, 1);
    chk(pdiv == 1, "R11 reset pdiv", pdiv, 1);
    chk(!dvs_mode && cpu_hz == 0, "R11 reset mode/cpu", cpu_hz, 0);
    chk(!done && !invalid, "R11 reset flags", {done, invalid}, 0);
    rst_n = 1'b1;
    run(400000000, 400000000, 133333333, 66666666, "R1 nominal", 0);
    run(400000000, 400000000, 133332333, 66666666, "R2 tolerance edge", 0);
    run(400000000, 400000000, 133332332, 66666666, "R2 beyond tolerance", 0);
    run(400000000, 500000000, 400000000, 400000000, "R3 clamp", 0);
    run(400000000, 100000000, 133333333, 66666666, "R4 limit lowered", 0);
    run(400000000, 400000000, 1000, 1000, "R5 no divisor", 0);
    run(400000000, 400000000, 400000000, 100000000, "R6 ratio too high", 0);
    run(300000000, 300000000, 60000000, 30000000, "R1 skips five", 0);
    run(400000000, 400000000, 200000000, 100000000, "R9 valid after invalid", 0);
    run(400000000, 400000000, 133333333, 66666666, "R10 busy start", 1);
    for (int k = 0; k < 250; k++) begin
      c = 1000000 + longint'($urandom % 400000000);
      h = c / (1 + $urandom % 12) + longint'($urandom % 2000);
      p = h / (1 + $urandom % 3) + longint'($urandom % 2000);
      m = $urandom % 3;
      r = (m == 0) ? c + longint'($urandom % 1000000) : (m == 1) ? c : c / (1 + $urandom % 6);
      run(c, r, h, p, "R8 random", 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule